// File: doc/BRIEF.md
# DMA Single-Channel Transfer Sequencer

This block runs the handshake for one DMA channel, one unit at a time. A peripheral raises a request line. The sequencer then asks the bus owner for the bus and waits for the grant. Only after the grant does it raise an acknowledge toward the peripheral. A transfer unit is one byte or one 16-bit word, set by a parameter. In peripheral-to-memory mode, the peripheral drives its data while acknowledge is high. The sequencer captures that data and then writes it to memory with a write strobe. In memory-to-peripheral mode, the sequencer reads the word from memory first and only then raises acknowledge, so the peripheral can latch the fetched word.

An external address/count unit tells the sequencer, through `last_unit`, whether the unit about to start is the final one. The sequencer pulses `xfer_step` once per finished unit so that unit can advance. On the final unit, terminal count rises in the same cycle as acknowledge. After that unit ends, the channel disables itself and ignores further requests until software arms it again. The transfer direction is latched when the channel is armed.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset every output is low and the channel is disabled, so a request on `dreq` raises no `hold_req` until `arm` is pulsed.
- R2: With the channel armed, idle, `hold_ack` low and `dreq` high, `hold_req` is high in the cycle after the request is seen. `dack` is never high unless `hold_ack` is high.
- R3: Direction 0 (`arm_dir` = 0) is peripheral-to-memory. `per_rdata` is captured in the `dack` cycle. `mem_wr` is then raised in a later cycle and held until `mem_ready`, with `mem_wdata` equal to the captured word. `mem_rd` never rises in this mode.
- R4: Direction 1 is memory-to-peripheral. `mem_rd` is held until `mem_ready` and completes before `dack` rises. During `dack`, `per_wdata` equals the fetched `mem_rdata`. `mem_wr` never rises in this mode.
- R5: `tc` is high only together with `dack`, and only on the unit for which `last_unit` was high when that unit's request was accepted.
- R6: `dack` is high for exactly one cycle per unit, and `xfer_step` pulses exactly once per unit.
- R7: At the end of each unit, `hold_req` and `dack` are low. If `dreq` stays high and the unit was not the last, a new sequence starts once `hold_ack` has dropped.
- R8: After the unit that carried `tc`, the channel is disabled: `dreq` raises no `hold_req` until `arm` is pulsed again.
- R9: `arm` is accepted only while the sequencer is idle, and it latches `arm_dir`. Changes on `arm_dir` outside an accepted `arm` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Pulse that enables the channel and latches the direction |
| arm_dir | input | 1 | Direction latched on arm: 0 peripheral-to-memory, 1 memory-to-peripheral |
| dreq | input | 1 | Transfer request from the peripheral |
| last_unit | input | 1 | From the count unit: the next unit is the final one |
| hold_ack | input | 1 | Bus grant from the bus owner |
| mem_ready | input | 1 | Memory completes the current read or write |
| mem_rdata | input | DATA_W | Memory read data |
| per_rdata | input | DATA_W | Data driven by the peripheral during acknowledge |
| hold_req | output | 1 | Bus request toward the bus owner |
| dack | output | 1 | Acknowledge toward the peripheral |
| tc | output | 1 | Terminal count, high during the final acknowledge |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DATA_W | Memory write data |
| per_wdata | output | DATA_W | Data presented to the peripheral |
| xfer_step | output | 1 | One-cycle pulse per finished unit |

## Verification
The main function is driven from a table of transfers. The table varies direction, the number of units in a held request, the grant delay and the memory wait states, so data ordering is checked both with zero latency and with long stalls on each handshake. Transfers that end with terminal count are mixed with transfers that do not. This separates the self-disable path from the back-to-back restart path. Directed cases cover the reset state, requests on a channel that was never armed, the disabled state after terminal count followed by re-arming, and an `arm` with the opposite direction arriving in the middle of a transfer.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ   = 3'd1,
        ST_FETCH = 3'd2,
        ST_ACK   = 3'd3,
        ST_WRITE = 3'd4,
        ST_DONE  = 3'd5
    } seq_state_t;

    typedef enum logic {
        DIR_P2M = 1'b0,
        DIR_M2P = 1'b1
    } xfer_dir_t;

    typedef struct packed {
        logic hold_req;
        logic dack;
        logic mem_rd;
        logic mem_wr;
        logic step;
    } seq_ctl_t;

    function automatic int unit_width(input int unit_bytes);
        return 8 * unit_bytes;
    endfunction

    function automatic seq_ctl_t decode_ctl(input seq_state_t s);
        seq_ctl_t c;
        c = '0;
        case (s)
            ST_REQ:   c.hold_req = 1'b1;
            ST_FETCH: begin c.hold_req = 1'b1; c.mem_rd = 1'b1; end
            ST_ACK:   begin c.hold_req = 1'b1; c.dack = 1'b1; end
            ST_WRITE: begin c.hold_req = 1'b1; c.mem_wr = 1'b1; end
            ST_DONE:  c.step = 1'b1;
            default:  c = '0;
        endcase
        return c;
    endfunction

    function automatic logic needs_fetch(input xfer_dir_t d);
        return d == DIR_M2P;
    endfunction

endpackage

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
    import dma_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      arm,
    input  logic      arm_dir,
    input  logic      idle,
    input  logic      final_done,
    output logic      en,
    output xfer_dir_t dir
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en  <= 1'b0;
            dir <= DIR_P2M;
        end else if (final_done) begin
            en  <= 1'b0;
        end else if (arm && idle) begin
            en  <= 1'b1;
            dir <= xfer_dir_t'(arm_dir);
        end
    end

    assert_disable_after_tc_R8: assert property (@(posedge clk) disable iff (rst)
        final_done |=> !en);

    assert_dir_held_busy_R9: assert property (@(posedge clk) disable iff (rst)
        !idle |=> $stable(dir));

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
    import dma_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  xfer_dir_t dir,
    input  logic      dreq,
    input  logic      hold_ack,
    input  logic      last_unit,
    input  logic      mem_ready,
    output seq_ctl_t  ctl,
    output logic      tc,
    output logic      idle,
    output logic      final_done,
    output logic      cap_per,
    output logic      cap_mem
);

    seq_state_t state, state_nx;
    logic       last_q;

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:  if (en && dreq && !hold_ack) state_nx = ST_REQ;
            ST_REQ:   if (hold_ack) state_nx = needs_fetch(dir) ? ST_FETCH : ST_ACK;
            ST_FETCH: if (mem_ready) state_nx = ST_ACK;
            ST_ACK:   state_nx = needs_fetch(dir) ? ST_DONE : ST_WRITE;
            ST_WRITE: if (mem_ready) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            last_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && state_nx == ST_REQ)
                last_q <= last_unit;
        end
    end

    assign ctl        = decode_ctl(state);
    assign tc         = ctl.dack && last_q;
    assign idle       = (state == ST_IDLE);
    assign final_done = ctl.step && last_q;
    assign cap_per    = ctl.dack && !needs_fetch(dir);
    assign cap_mem    = ctl.mem_rd && mem_ready;

    assert_req_after_drq_R2: assert property (@(posedge clk) disable iff (rst)
        (idle && en && dreq && !hold_ack) |=> ctl.hold_req);

    assert_dack_needs_grant_R2: assert property (@(posedge clk) disable iff (rst)
        ctl.dack |-> hold_ack);

    assert_write_after_ack_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl.mem_wr) |-> $past(ctl.dack));

    assert_fetch_before_ack_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(ctl.dack) && dir == DIR_M2P) |-> $past(ctl.mem_rd && mem_ready));

    assert_tc_in_dack_R5: assert property (@(posedge clk) disable iff (rst)
        tc |-> ctl.dack);

    assert_dack_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        ctl.dack |=> !ctl.dack);

    assert_release_after_unit_R7: assert property (@(posedge clk) disable iff (rst)
        ctl.step |-> (!ctl.hold_req && !ctl.dack));

endmodule

// File: rtl/dma_seq_data.sv
module dma_seq_data #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_per,
    input  logic              cap_mem,
    input  logic [DATA_W-1:0] per_rdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] word_q
);

    always_ff @(posedge clk) begin
        if (rst)
            word_q <= '0;
        else if (cap_per)
            word_q <= per_rdata;
        else if (cap_mem)
            word_q <= mem_rdata;
    end

    assert_single_capture_R3: assert property (@(posedge clk) disable iff (rst)
        !(cap_per && cap_mem));

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
    import dma_seq_pkg::*;
#(
    parameter  int UNIT_BYTES = 2,
    localparam int DATA_W     = unit_width(UNIT_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic              arm_dir,
    input  logic              dreq,
    input  logic              last_unit,
    input  logic              hold_ack,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] per_rdata,
    output logic              hold_req,
    output logic              dack,
    output logic              tc,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] per_wdata,
    output logic              xfer_step
);

    logic        en, idle, final_done, cap_per, cap_mem;
    xfer_dir_t   dir;
    seq_ctl_t    ctl;
    logic [DATA_W-1:0] word_q;

    dma_chan_ctl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .arm        (arm),
        .arm_dir    (arm_dir),
        .idle       (idle),
        .final_done (final_done),
        .en         (en),
        .dir        (dir)
    );

    dma_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .dir        (dir),
        .dreq       (dreq),
        .hold_ack   (hold_ack),
        .last_unit  (last_unit),
        .mem_ready  (mem_ready),
        .ctl        (ctl),
        .tc         (tc),
        .idle       (idle),
        .final_done (final_done),
        .cap_per    (cap_per),
        .cap_mem    (cap_mem)
    );

    dma_seq_data #(.DATA_W(DATA_W)) u_data (
        .clk        (clk),
        .rst        (rst),
        .cap_per    (cap_per),
        .cap_mem    (cap_mem),
        .per_rdata  (per_rdata),
        .mem_rdata  (mem_rdata),
        .word_q     (word_q)
    );

    assign hold_req  = ctl.hold_req;
    assign dack      = ctl.dack;
    assign mem_rd    = ctl.mem_rd;
    assign mem_wr    = ctl.mem_wr;
    assign xfer_step = ctl.step;
    assign mem_wdata = word_q;
    assign per_wdata = word_q;

    assert_strobes_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        !((mem_rd || mem_wr) && dack));

    assert_no_req_disabled_R8: assert property (@(posedge clk) disable iff (rst)
        (!en && idle) |=> !hold_req);

endmodule

// File: tb/dma_xfer_seq_test.sv
`timescale 1ns/1ps
module dma_xfer_seq_test;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          arm = 1'b0, arm_dir = 1'b0, dreq = 1'b0, last_unit = 1'b0;
    logic          hold_ack = 1'b0, mem_ready = 1'b0;
    logic [DW-1:0] mem_rdata = '0, per_rdata = '0;
    logic          hold_req, dack, tc, mem_rd, mem_wr, xfer_step;
    logic [DW-1:0] mem_wdata, per_wdata;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    dma_xfer_seq #(.UNIT_BYTES(2)) uut (
        .clk(clk), .rst(rst), .arm(arm), .arm_dir(arm_dir), .dreq(dreq),
        .last_unit(last_unit), .hold_ack(hold_ack), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .per_rdata(per_rdata), .hold_req(hold_req),
        .dack(dack), .tc(tc), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .per_wdata(per_wdata), .xfer_step(xfer_step)
    );

    // fields: [41] dir, [40] final is last, [39:38] units, [37:35] grant delay,
    // [34:32] memory waits, [31:16] peripheral word, [15:0] memory word
    localparam logic [41:0] VEC [6] = '{
        {1'b0, 1'b0, 2'd1, 3'd0, 3'd0, 16'hA5C3, 16'h0000},
        {1'b1, 1'b0, 2'd1, 3'd2, 3'd1, 16'h0000, 16'h3C5A},
        {1'b0, 1'b1, 2'd2, 3'd1, 3'd3, 16'h1234, 16'h0000},
        {1'b1, 1'b1, 2'd3, 3'd3, 3'd0, 16'h0000, 16'hBEEF},
        {1'b0, 1'b0, 2'd3, 3'd4, 3'd2, 16'hFFFF, 16'h0000},
        {1'b1, 1'b1, 2'd1, 3'd0, 3'd4, 16'h0000, 16'h8001}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            finish_run();
        end
    end

    task automatic do_arm(input logic d);
        @(negedge clk);
        arm = 1'b1; arm_dir = d;
        @(negedge clk);
        arm = 1'b0; arm_dir = ~d;   // R9: later changes must not matter
    endtask

    // Runs n units with dreq held high, acting as bus owner and memory.
    task automatic run_units(input logic dir, input logic fin_last, input int n,
                             input int gd, input int md,
                             input logic [DW-1:0] pd, input logic [DW-1:0] mdat);
        int  ndack = 0, nstep = 0, ntc = 0, gcnt = 0, mcnt = 0, k = 0;
        bit  dack_seen = 0, fetched = 0, saw_rd = 0, saw_wr = 0, first = 1;
        per_rdata = pd; mem_rdata = mdat;
        last_unit = fin_last && (n == 1);
        dreq = 1'b1;
        while (nstep < n && k < 200) begin
            @(negedge clk);
            k++;
            if (first) begin
                check("R2 hold_req one cycle after dreq", {31'd0, hold_req}, 32'd1);
                first = 0;
            end
            if (dack) begin
                ndack++;
                dack_seen = 1;
                check("R2 dack only with grant", {31'd0, hold_ack}, 32'd1);
                check("R5 tc during dack", {31'd0, tc},
                      {31'd0, fin_last && (nstep == n - 1)});
                if (tc) ntc++;
                if (dir) begin
                    check("R4 fetch done before dack", {31'd0, fetched}, 32'd1);
                    check("R4 per_wdata", {16'd0, per_wdata}, {16'd0, mdat});
                end
            end else if (tc) begin
                check("R5 tc outside dack", 32'd1, 32'd0);
            end
            if (mem_wr) begin
                saw_wr = 1;
                check("R3 write after dack", {31'd0, dack_seen}, 32'd1);
                check("R3 mem_wdata", {16'd0, mem_wdata}, {16'd0, pd});
            end
            if (mem_rd) begin
                saw_rd = 1;
                if (dack_seen) check("R4 read after dack", 32'd1, 32'd0);
            end
            if (xfer_step) begin
                nstep++;
                check("R7 released at unit end", {30'd0, hold_req, dack}, 32'd0);
                check("R6 one dack per unit", ndack, nstep);
                dack_seen = 0; fetched = 0;
                last_unit = fin_last && (nstep == n - 1);
            end
            // bus owner model
            if (hold_req) begin
                hold_ack = (gcnt >= gd);
                gcnt++;
            end else begin
                hold_ack = 1'b0; gcnt = 0;
            end
            // memory model
            if (mem_rd || mem_wr) begin
                mem_ready = (mcnt >= md);
                mcnt++;
                if (mem_rd && mem_ready) fetched = 1;
            end else begin
                mem_ready = 1'b0; mcnt = 0;
            end
        end
        check("R6 step count", nstep, n);
        check("R6 dack count", ndack, n);
        check("R5 tc count", ntc, {31'd0, fin_last});
        check(dir ? "R4 no write in m2p" : "R3 no read in p2m",
              {31'd0, dir ? saw_wr : saw_rd}, 32'd0);
        check(dir ? "R4 read seen" : "R3 write seen",
              {31'd0, dir ? saw_rd : saw_wr}, 32'd1);
        @(negedge clk);
        hold_ack = 1'b0; mem_ready = 1'b0;
    endtask

    task automatic expect_quiet(input string req, input int cycles);
        bit seen = 0;
        dreq = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (hold_req || dack || mem_rd || mem_wr) seen = 1;
        end
        check(req, {31'd0, seen}, 32'd0);
        dreq = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 outputs low after reset",
              {26'd0, hold_req, dack, tc, mem_rd, mem_wr, xfer_step}, 32'd0);
        check("R1 data outputs low", {mem_wdata, per_wdata}, 32'd0);
        expect_quiet("R1 unarmed channel ignores dreq", 6);

        // table walk
        for (int v = 0; v < 6; v++) begin
            do_arm(VEC[v][41]);
            run_units(VEC[v][41], VEC[v][40], int'(VEC[v][39:38]),
                      int'(VEC[v][37:35]), int'(VEC[v][34:32]),
                      VEC[v][31:16], VEC[v][15:0]);
            if (VEC[v][40]) expect_quiet("R8 disabled after tc", 8);
            dreq = 1'b0;
            @(negedge clk);
        end

        // R8: re-arm after tc restores service
        do_arm(1'b0);
        run_units(1'b0, 1'b0, 1, 1, 1, 16'h5AA5, 16'h0000);
        dreq = 1'b0;

        // R9: arm with opposite direction mid-transfer is ignored
        do_arm(1'b0);
        begin
            bit rd_seen = 0, wr_seen = 0;
            int gcnt = 0, mcnt = 0;
            per_rdata = 16'h0F0F; last_unit = 1'b0;
            dreq = 1'b1;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                arm = (i == 1); arm_dir = 1'b1;
                if (mem_rd) rd_seen = 1;
                if (mem_wr) begin
                    wr_seen = 1;
                    check("R9 data of p2m unit", {16'd0, mem_wdata}, 32'h0F0F);
                end
                if (hold_req) begin hold_ack = (gcnt >= 2); gcnt++; end
                else begin hold_ack = 1'b0; gcnt = 0; end
                if (mem_rd || mem_wr) begin mem_ready = (mcnt >= 1); mcnt++; end
                else begin mem_ready = 1'b0; mcnt = 0; end
                if (xfer_step) dreq = 1'b0;
            end
            arm = 1'b0;
            check("R9 busy arm kept direction (no read)", {31'd0, rd_seen}, 32'd0);
            check("R9 busy arm kept direction (write)", {31'd0, wr_seen}, 32'd1);
        end
        hold_ack = 1'b0; mem_ready = 1'b0;
        // R7: channel still armed, next request serviced in same direction
        run_units(1'b0, 1'b1, 2, 0, 0, 16'h7E7E, 16'h0000);
        expect_quiet("R8 disabled after final unit", 6);
        finish_run();
    end

endmodule